// File: doc/BRIEF.md
# Logically Cleared Single-Port RAM

This block wraps a synchronous single-port data memory. Software or a sequencer can wipe the whole memory in one request without rewriting the data array. Each data word has a presence flag. A write stores the word and raises its flag. A read returns the stored word when the flag is set and returns zeros when it is not. A clear request drops every flag, so from then on every word reads as zero until it is written again.

The parameter `FLAG_RAM` selects how the flags are stored.
- **Flop form (`FLAG_RAM=0`):** the flags live in one flip-flop per word, and a clear takes effect at the next clock edge.
- **Banked form (`FLAG_RAM=1`):** the flags live in small 16-entry flag RAMs. Entry `addr[3:0]` holds one bit per bank, and the bank is selected by the upper address bits. A clear then sweeps the 16 entries, one per cycle, while `busy_o` is high. The same sweep runs after reset, because the small RAMs have no reset.

While `busy_o` is high, accesses are dropped, so the requester must stall until it falls. Reads have a latency of one cycle. The flag is read at the same edge as the data, so the zero mux sits after both registers.

Top module: `fastclr_ram`

## Requirements
- R1: After reset `rdata_o` is zero. In the flop form `busy_o` is low. In the banked form `busy_o` is high during reset and for the first 16 clock edges after reset is released, and is low after that.
- R2: An accepted write stores `wdata_i` at `addr_i` and marks that word present. An accepted read of that word returns the data on `rdata_o` after the next edge.
- R3: An accepted read of a word not written since the last clear (or since reset) returns all zeros.
- R4: After an accepted clear, every word reads as zero until it is written again. In the flop form this holds from the edge that samples the clear.
- R5: A write on the same cycle as an accepted clear is dropped, so the word still reads zero afterwards.
- R6: `rdata_o` changes only after an accepted read, and holds its value otherwise.
- R7: In the banked form an accepted clear raises `busy_o` at the next edge and keeps it high for exactly 16 cycles.
- R8: In the banked form, reads and writes issued while `busy_o` is high are ignored. A read leaves `rdata_o` unchanged, and a dropped write leaves the word reading zero.
- R9: A read and a write to the same address in the same cycle return the contents from before that write.
- R10: In the banked form a clear request while `busy_o` is high is ignored and does not lengthen the sweep.
- R11: A read on the same cycle as an accepted clear returns the contents from before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Logical clear request for the whole memory |
| wr_en_i | input | 1 | Write request |
| rd_en_i | input | 1 | Read request |
| addr_i | input | ADDR_W | Word address for a read or a write |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, one cycle after an accepted read |
| busy_o | output | 1 | High while the flag sweep runs (banked form only) |

## Verification
A flag stuck high shows up as stale data from a word read after a clear. A flag stuck low shows up as zeros where written data was expected. Either one appears on `rdata_o` one cycle after the first read of that word. A sweep counter that is off by one, or a clear that restarts the sweep, shows up on `busy_o` as a wrong high-time at the edge where the busy window should end. A sweep that misses an entry shows up as stale data from the first read of a word held in that entry. The bench runs both forms side by side against a word-level model, so each of these faults is reported at the cycle it first becomes visible.

// File: rtl/fastclr_ram.sv
module fastclr_ram #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int FLAG_RAM = 1,
  parameter int FLAG_AW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int FDEPTH = 1 << FLAG_AW;
  localparam int BANK_W = ADDR_W - FLAG_AW;
  localparam int NBANK  = 1 << BANK_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;
  logic              vld_q;
  logic              flag_rd;
  logic              busy;
  logic              wr_acc, rd_acc;

  assign wr_acc  = wr_en_i & ~clr_i & ~busy;
  assign rd_acc  = rd_en_i & ~busy;
  assign rdata_o = vld_q ? rdata_q : '0;
  assign busy_o  = busy;

  always_ff @(posedge clk) begin
    if (wr_acc) mem[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      vld_q   <= 1'b0;
    end else if (rd_acc) begin
      rdata_q <= mem[addr_i];
      vld_q   <= flag_rd;
    end
  end

  generate
    if (FLAG_RAM == 0) begin : g_flop
      logic [DEPTH-1:0] vld_ff;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      vld_ff <= '0;
        else if (clr_i)  vld_ff <= '0;
        else if (wr_acc) vld_ff[addr_i] <= 1'b1;
      end

      assign flag_rd = vld_ff[addr_i];
      assign busy    = 1'b0;

      assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (vld_ff == '0));
      assert_write_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !clr_i) |=> vld_ff[$past(addr_i)]);
    end else begin : g_bank
      logic [NBANK-1:0]   fmem [FDEPTH];
      logic [FLAG_AW-1:0] sweep_idx;
      logic               sweeping;
      logic [FLAG_AW:0]   chk_cnt;
      logic [FLAG_AW-1:0] a_lo;
      logic [BANK_W-1:0]  a_hi;

      assign a_lo = addr_i[FLAG_AW-1:0];
      assign a_hi = addr_i[ADDR_W-1:FLAG_AW];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sweeping  <= 1'b1;
          sweep_idx <= '0;
        end else if (sweeping) begin
          sweep_idx <= sweep_idx + 1'b1;
          if (sweep_idx == FLAG_AW'(FDEPTH - 1)) sweeping <= 1'b0;
        end else if (clr_i) begin
          sweeping  <= 1'b1;
          sweep_idx <= '0;
        end
      end

      always_ff @(posedge clk) begin
        if (sweeping)    fmem[sweep_idx] <= '0;
        else if (wr_acc) fmem[a_lo][a_hi] <= 1'b1;
      end

      assign flag_rd = fmem[a_lo][a_hi];
      assign busy    = sweeping;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      chk_cnt <= '0;
        else if (busy_o) chk_cnt <= chk_cnt + 1'b1;
        else             chk_cnt <= '0;
      end

      assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !busy_o) |=> busy_o);
      assert_sweep_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (chk_cnt < (FLAG_AW+1)'(FDEPTH)));
      assert_sweep_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(chk_cnt) == (FLAG_AW+1)'(FDEPTH - 1)));
    end
  endgenerate

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en_i && !busy_o) |=> $stable(rdata_o));
  assert_zero_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !busy_o && !flag_rd) |=> (rdata_o == '0));
endmodule

// File: tb/fastclr_ram_tb.sv
module fastclr_ram_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int N  = 1 << AW;
  localparam int SWEEP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, we = 1'b0, re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_ram, rd_ff;
  logic busy_ram, busy_ff;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] mr_mem [N];
  logic [DW-1:0] mf_mem [N];
  logic          mr_vld [N];
  logic          mf_vld [N];
  logic [DW-1:0] exp_r, exp_f;
  int            busy_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  fastclr_ram #(.DATA_W(DW), .ADDR_W(AW), .FLAG_RAM(1), .FLAG_AW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .wr_en_i(we), .rd_en_i(re),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_ram), .busy_o(busy_ram));

  fastclr_ram #(.DATA_W(DW), .ADDR_W(AW), .FLAG_RAM(0), .FLAG_AW(4)) dut_ff_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .wr_en_i(we), .rd_en_i(re),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_ff), .busy_o(busy_ff));

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic logic [DW-1:0] model_read(input logic v, input logic [DW-1:0] d);
    return v ? d : '0;
  endfunction

  // drive one cycle, update the models at the edge, compare at the next falling edge
  task automatic step(input logic c, input logic w, input logic r,
                      input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    logic rbusy;
    clr = c; we = w; re = r; addr = a; wdata = d;
    @(posedge clk);
    rbusy = (busy_cnt > 0);
    if (r) exp_f = model_read(mf_vld[a], mf_mem[a]);
    if (r && !rbusy) exp_r = model_read(mr_vld[a], mr_mem[a]);
    if (c) begin
      for (int i = 0; i < N; i++) mf_vld[i] = 1'b0;
    end else if (w) begin
      mf_mem[a] = d; mf_vld[a] = 1'b1;
    end
    if (rbusy) busy_cnt--;
    else if (c) begin
      for (int i = 0; i < N; i++) mr_vld[i] = 1'b0;
      busy_cnt = SWEEP;
    end else if (w) begin
      mr_mem[a] = d; mr_vld[a] = 1'b1;
    end
    @(negedge clk);
    chk({tag, " flop rdata"}, rd_ff, exp_f);
    chk({tag, " banked rdata"}, rd_ram, exp_r);
    chk({tag, " banked busy"}, DW'(busy_ram), DW'(busy_cnt > 0));
    chk({tag, " flop busy"}, DW'(busy_ff), '0);
  endtask

  task automatic wait_idle(input string tag);
    while (busy_cnt > 0) step(1'b0, 1'b0, 1'b0, '0, '0, tag);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        summary();
      end
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    for (int i = 0; i < N; i++) begin
      mr_vld[i] = 1'b0; mf_vld[i] = 1'b0; mr_mem[i] = '0; mf_mem[i] = '0;
    end
    exp_r = '0; exp_f = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset flop rdata", rd_ff, '0);
    chk("R1 reset banked rdata", rd_ram, '0);
    chk("R1 reset banked busy", DW'(busy_ram), 1);
    chk("R1 reset flop busy", DW'(busy_ff), '0);
    rst_n = 1'b1;
    busy_cnt = SWEEP;
    // R8 reads and writes while the power-up sweep runs are dropped
    step(1'b0, 1'b1, 1'b0, 6'd5, 32'hDEAD_0005, "R8 write during sweep");
    step(1'b0, 1'b0, 1'b1, 6'd5, '0, "R8 read during sweep");
    wait_idle("R1 power-up sweep");
    step(1'b0, 1'b0, 1'b1, 6'd5, '0, "R8 dropped write reads zero");

    // R2 and R3 directed
    step(1'b0, 1'b1, 1'b0, 6'd0,  32'h1111_0000, "R2 write");
    step(1'b0, 1'b1, 1'b0, 6'd17, 32'h2222_0011, "R2 write");
    step(1'b0, 1'b1, 1'b0, 6'd63, 32'hFFFF_FFFF, "R2 write");
    step(1'b0, 1'b0, 1'b1, 6'd17, '0, "R2 read back");
    step(1'b0, 1'b0, 1'b1, 6'd63, '0, "R2 read back");
    step(1'b0, 1'b0, 1'b1, 6'd1,  '0, "R3 unwritten");
    step(1'b0, 1'b0, 1'b0, 6'd0,  '0, "R6 hold");
    step(1'b0, 1'b1, 1'b0, 6'd2,  32'h5555_AAAA, "R6 write no read");
    // R9 read-first
    step(1'b0, 1'b1, 1'b1, 6'd17, 32'h3333_0011, "R9 same-cycle read/write");
    step(1'b0, 1'b0, 1'b1, 6'd17, '0, "R9 new data after");
    step(1'b0, 1'b1, 1'b1, 6'd33, 32'h4444_0021, "R9 unwritten same-cycle");
    // R11 and R5: clear with read and write
    step(1'b1, 1'b1, 1'b1, 6'd17, 32'hBAD0_BAD0, "R11 R5 clear with access");
    step(1'b1, 1'b0, 1'b0, 6'd0, '0, "R10 clear while busy");
    step(1'b0, 1'b1, 1'b1, 6'd0, 32'h7777_7777, "R8 access while busy");
    wait_idle("R7 sweep window");
    for (int i = 0; i < N; i++) step(1'b0, 1'b0, 1'b1, AW'(i), '0, "R4 R5 all zero after clear");
    step(1'b0, 1'b1, 1'b0, 6'd9, 32'h0909_0909, "R4 rewrite after clear");
    step(1'b0, 1'b0, 1'b1, 6'd9, '0, "R4 rewritten word");
    step(1'b0, 1'b0, 1'b1, 6'd10, '0, "R4 neighbour still zero");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic c, w, r;
      c = ($urandom % 80) == 0;
      w = ($urandom % 2) == 0;
      r = ($urandom % 2) == 0;
      step(c, w, r, AW'($urandom), $urandom, "R2 R3 R4 R6 R8 random");
    end
    wait_idle("R7 final");
    summary();
  end
endmodule